// File: doc/BRIEF.md
# Sub-Sample Pulse Timing Pick-Off

This block puts a fine timestamp on scintillation pulses that arrive in the sample stream of a free-running ADC. The converter is not locked to pulse arrival, so a pulse can start anywhere inside a sample period. The block arms and waits for the first valid sample that rises above a programmable threshold. That sample, called the trigger sample, is the only one used for timing. The block then sums the area of a fixed window of valid samples that starts at the trigger sample. A linear calibration with a programmable slope and offset turns that area into an amplitude estimate.

The trigger sample is divided by the estimated amplitude, which gives an 8-bit code for the voltage on a reference curve of unit amplitude. A 256-entry table, filled by software from a reference pulse with fixed rise and decay constants, maps that code to the delay t0 from the pulse start to the trigger sample. t0 is a fraction of a sample period with 6 bits of resolution. The reported start time is the coarse sample count of the trigger sample, extended by six fractional bits, minus t0.

After a result the block stays blind until the input drops back to or below the threshold. This keeps the tail of the same pulse from firing a second trigger. The table and the calibration registers are written through one address/data/write-enable port, and writes take effect only while the block is armed and waiting.

Top module: `tp_timing_pickoff`

## Requirements
- R1: After reset, `ts_valid` is low and `ts` is zero.
- R2: A coarse counter counts valid samples modulo 2^16 and starts at 0 after reset. While armed, the first valid sample strictly greater than the threshold is the trigger sample, and its coarse time is the number of valid samples accepted before it. A sample equal to the threshold does not trigger.
- R3: The area is the sum of 13 valid samples, starting with the trigger sample. Cycles with `s_valid` low add nothing, whatever value `s_data` carries.
- R4: The amplitude is floor(area*slope/256) + offset, clamped to the range 1 to 4095.
- R5: The table index is floor(trigger*256/amplitude). It saturates to 255 when the trigger sample is greater than or equal to the amplitude.
- R6: `ts` = ({coarse, 6'b0} − t0) modulo 2^22, where t0 is the 6-bit table entry at that index. The subtraction borrows from the coarse part.
- R7: `ts_valid` is a one-cycle pulse that rises exactly 11 clock cycles after the edge that accepted the last window sample. `ts` holds its value until the next result.
- R8: Samples are ignored from the end of the window until a result is out. After that, the block does not trigger again until a valid sample at or below the threshold arrives, so each pulse gives exactly one result.
- R9: A configuration write with `cfg_addr[8]`=0 sets table entry `cfg_addr[7:0]` to `cfg_wdata[5:0]`. With `cfg_addr[8]`=1, address 0x100 sets the threshold (`cfg_wdata[11:0]`), 0x101 sets the slope and 0x102 sets the offset. Writes are accepted only while armed and waiting for a trigger, and are ignored in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample strobe |
| s_data | input | 12 | Unsigned sample magnitude |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 9 | Table index, or register select when bit 8 is set |
| cfg_wdata | input | 16 | Configuration write data |
| ts_valid | output | 1 | Timestamp strobe |
| ts | output | 22 | {coarse[15:0], fine[5:0]} start time |

## Verification
Synthetic two-exponential pulses are driven at several amplitudes and start fractions, and each timestamp is compared exactly with a model built from the requirements. The first pulse triggers on sample zero, so the coarse part must borrow. Three calibrations steer the divider into its quotient and saturation paths: a zero slope, a large slope and a small fixed offset. Invalid cycles carrying full-scale data show that the area counts only valid samples. A run of samples equal to the threshold, a raised threshold and a long plateau after the window check the trigger rule and the blind period. A table write issued mid-pulse must leave the result unchanged.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [2:0] {
    ST_ARM,
    ST_INTEG,
    ST_CALC,
    ST_DIV,
    ST_LOOK,
    ST_BLIND
  } tp_state_e;

  localparam int unsigned CFG_THR    = 0;
  localparam int unsigned CFG_SLOPE  = 1;
  localparam int unsigned CFG_OFFSET = 2;
endpackage

// File: rtl/tp_amp_est.sv
module tp_amp_est #(
  parameter int SW    = 12,
  parameter int AREAW = 16,
  parameter int CFW   = 16,
  parameter int FRAC  = 8
) (
  input  logic [AREAW-1:0] area,
  input  logic [CFW-1:0]   slope,
  input  logic [CFW-1:0]   offset,
  output logic [SW-1:0]    amp
);
  localparam int PW = AREAW + CFW;
  localparam logic [PW:0] AMP_MAX = (PW+1)'((1 << SW) - 1);

  logic [PW-1:0] prod;
  logic [PW-1:0] scaled;
  logic [PW:0]   sum;

  always_comb begin
    prod   = PW'(area) * PW'(slope);
    scaled = prod >> FRAC;
    sum    = {1'b0, scaled} + (PW+1)'(offset);
    if (sum == '0)          amp = SW'(1);
    else if (sum > AMP_MAX) amp = AMP_MAX[SW-1:0];
    else                    amp = sum[SW-1:0];
  end
endmodule

// File: rtl/tp_divider.sv
module tp_divider #(
  parameter int NW = 12,
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          done,
  output logic [QW-1:0] quo
);
  localparam int CNTW = $clog2(QW + 1);

  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [NW-1:0]   rem_q, rem_n, den_q, den_n, num_q, num_n;
  logic [QW-1:0]   quo_q, quo_n;
  logic            sat_q, sat_n, done_q, done_n;
  logic [NW:0]     shifted;

  always_comb begin
    cnt_n   = cnt_q;
    rem_n   = rem_q;
    den_n   = den_q;
    num_n   = num_q;
    quo_n   = quo_q;
    sat_n   = sat_q;
    done_n  = 1'b0;
    shifted = {rem_q, 1'b0};
    if (start) begin
      rem_n = num;
      num_n = num;
      den_n = den;
      quo_n = '0;
      sat_n = (num >= den);
      cnt_n = CNTW'(QW);
    end else if (cnt_q != '0) begin
      if (shifted >= {1'b0, den_q}) begin
        rem_n = NW'(shifted - {1'b0, den_q});
        quo_n = {quo_q[QW-2:0], 1'b1};
      end else begin
        rem_n = shifted[NW-1:0];
        quo_n = {quo_q[QW-2:0], 1'b0};
      end
      cnt_n  = cnt_q - CNTW'(1);
      done_n = (cnt_q == CNTW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      quo_q  <= '0;
      sat_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      den_q  <= den_n;
      num_q  <= num_n;
      quo_q  <= quo_n;
      sat_q  <= sat_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign quo  = sat_q ? {QW{1'b1}} : quo_q;

  // R4: a zero divisor never reaches the iteration
  a_r4_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (den_q != '0));

  // R5: an unsaturated quotient is the exact floor of num*2^QW/den
  a_r5_quot_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !sat_q) |->
      ((32'(quo_q) * 32'(den_q) <= (32'(num_q) << QW)) &&
       ((32'(quo_q) + 32'd1) * 32'(den_q) > (32'(num_q) << QW))));
endmodule

// File: rtl/tp_lut.sv
module tp_lut #(
  parameter int AW = 8,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/tp_timing_pickoff.sv
module tp_timing_pickoff
  import tp_pkg::*;
#(
  parameter int SW   = 12,
  parameter int CW   = 16,
  parameter int FW   = 6,
  parameter int WIN  = 13,
  parameter int TA   = 8,
  parameter int CFW  = 16,
  parameter int FRAC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic [SW-1:0]    s_data,
  input  logic             cfg_we,
  input  logic [TA:0]      cfg_addr,
  input  logic [CFW-1:0]   cfg_wdata,
  output logic             ts_valid,
  output logic [CW+FW-1:0] ts
);
  localparam int AREAW = SW + $clog2(WIN);
  localparam int WCW   = $clog2(WIN + 1);
  localparam int TSW   = CW + FW;

  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  tp_state_e        state_q, state_n;
  logic [CW-1:0]    crs_q, crs_n, tco_q, tco_n;
  logic [SW-1:0]    trig_q, trig_n, thr_q, thr_n;
  logic [AREAW-1:0] area_q, area_n;
  logic [WCW-1:0]   win_q, win_n;
  logic [CFW-1:0]   slope_q, slope_n, off_q, off_n;
  logic [TSW-1:0]   ts_q, ts_n;
  logic             tsv_q, tsv_n;

  logic           cfg_ok, tbl_we, div_start, div_done, lut_re;
  logic [SW-1:0]  amp;
  logic [TA-1:0]  div_quo;
  logic [FW-1:0]  t0;

  assign cfg_ok = cfg_we && (state_q == ST_ARM);
  assign tbl_we = cfg_ok && !cfg_addr[TA];

  always_comb begin
    state_n   = state_q;
    crs_n     = s_valid ? crs_q + CW'(1) : crs_q;
    tco_n     = tco_q;
    trig_n    = trig_q;
    area_n    = area_q;
    win_n     = win_q;
    thr_n     = thr_q;
    slope_n   = slope_q;
    off_n     = off_q;
    ts_n      = ts_q;
    tsv_n     = 1'b0;
    div_start = 1'b0;
    lut_re    = 1'b0;

    if (cfg_ok && cfg_addr[TA]) begin
      if (cfg_addr[TA-1:0] == TA'(CFG_THR))    thr_n   = cfg_wdata[SW-1:0];
      if (cfg_addr[TA-1:0] == TA'(CFG_SLOPE))  slope_n = cfg_wdata;
      if (cfg_addr[TA-1:0] == TA'(CFG_OFFSET)) off_n   = cfg_wdata;
    end

    unique case (state_q)
      ST_ARM: if (s_valid && (s_data > thr_q)) begin
        trig_n  = s_data;
        tco_n   = crs_q;
        area_n  = AREAW'(s_data);
        win_n   = WCW'(1);
        state_n = ST_INTEG;
      end
      ST_INTEG: if (s_valid) begin
        area_n = area_q + AREAW'(s_data);
        win_n  = win_q + WCW'(1);
        if (win_q == WCW'(WIN - 1)) state_n = ST_CALC;
      end
      ST_CALC: begin
        div_start = 1'b1;
        state_n   = ST_DIV;
      end
      ST_DIV: if (div_done) begin
        lut_re  = 1'b1;
        state_n = ST_LOOK;
      end
      ST_LOOK: begin
        ts_n    = {tco_q, {FW{1'b0}}} - {{CW{1'b0}}, t0};
        tsv_n   = 1'b1;
        state_n = ST_BLIND;
      end
      ST_BLIND: if (s_valid && (s_data <= thr_q)) state_n = ST_ARM;
      default: state_n = ST_ARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_ARM;
      crs_q   <= '0;
      tco_q   <= '0;
      trig_q  <= '0;
      area_q  <= '0;
      win_q   <= '0;
      thr_q   <= '0;
      slope_q <= '0;
      off_q   <= '0;
      ts_q    <= '0;
      tsv_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      crs_q   <= crs_n;
      tco_q   <= tco_n;
      trig_q  <= trig_n;
      area_q  <= area_n;
      win_q   <= win_n;
      thr_q   <= thr_n;
      slope_q <= slope_n;
      off_q   <= off_n;
      ts_q    <= ts_n;
      tsv_q   <= tsv_n;
    end
  end

  tp_amp_est #(.SW(SW), .AREAW(AREAW), .CFW(CFW), .FRAC(FRAC)) u_amp (
    .area(area_q), .slope(slope_q), .offset(off_q), .amp(amp)
  );

  tp_divider #(.NW(SW), .QW(TA)) u_div (
    .clk(clk), .rst_n(rst_i_n), .start(div_start), .num(trig_q), .den(amp),
    .done(div_done), .quo(div_quo)
  );

  tp_lut #(.AW(TA), .DW(FW)) u_lut (
    .clk(clk), .rst_n(rst_i_n), .we(tbl_we), .waddr(cfg_addr[TA-1:0]),
    .wdata(cfg_wdata[FW-1:0]), .re(lut_re), .raddr(div_quo), .rdata(t0)
  );

  assign ts_valid = tsv_q;
  assign ts       = ts_q;

  // R7: a result strobe lasts one cycle and follows a table read
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    ts_valid |=> !ts_valid);
  a_r7_after_lookup: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(ts_valid) |-> ($past(state_q) == ST_LOOK));

  // R3: the window counter stays inside the window while integrating
  a_r3_win_bound: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_INTEG) |-> ((win_q != '0) && (win_q < WCW'(WIN))));

  // R8: no direct retrigger out of the blind state
  a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_BLIND) |=> (state_q != ST_INTEG));

  // R9: calibration registers hold when a write arrives outside the armed state
  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_we && (state_q != ST_ARM)) |=>
      ($stable(thr_q) && $stable(slope_q) && $stable(off_q)));
endmodule

// File: tb/sim_tp_timing_pickoff.sv
module sim_tp_timing_pickoff;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid;
  logic [11:0] s_data;
  logic        cfg_we;
  logic [8:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        ts_valid;
  logic [21:0] ts;

  tp_timing_pickoff u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ts_valid(ts_valid), .ts(ts)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, nsamp = 0;
  int got_cnt = 0, got_cyc = 0;
  longint got_ts = 0;
  int tbl_m [256];
  int thr_m = 0, slope_m = 0, off_m = 0;
  int pbuf [0:39];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ts_valid === 1'b1) begin
      got_cnt = got_cnt + 1;
      got_ts  = longint'(ts);
      got_cyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(input int addr, input int data);
    @(negedge clk);
    s_valid = 1'b0; cfg_we = 1'b1; cfg_addr = 9'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < 256) tbl_m[addr] = data & 63;
    else if (addr == 256) thr_m = data & 4095;
    else if (addr == 257) slope_m = data;
    else if (addr == 258) off_m = data;
  endtask

  task automatic send(input int d, input bit v, output int edge_no);
    @(negedge clk);
    cfg_we = 1'b0; s_valid = v; s_data = 12'(d);
    edge_no = cyc + 1;
    if (v) nsamp++;
  endtask

  function automatic longint amp_of(longint area);
    longint a = ((area * slope_m) >> 8) + off_m;
    if (a < 1) a = 1;
    if (a > 4095) a = 4095;
    return a;
  endfunction

  function automatic int idx_of(int trig, longint area);
    longint a = amp_of(area);
    if (trig >= a) return 255;
    return int'((longint'(trig) * 256) / a);
  endfunction

  task automatic fill_pulse(input real amp, input real frac, input int pre);
    for (int i = 0; i < 40; i++) begin
      if (i < pre) pbuf[i] = 0;
      else begin
        real t = real'(i - pre) + frac;
        real v = amp * ($exp(-t / 2.44) - $exp(-t / 0.05));
        if (v < 0.0) v = 0.0;
        if (v > 4095.0) v = 4095.0;
        pbuf[i] = $rtoi(v);
      end
    end
  endtask

  task automatic run_pulse(input string req, input int len, input bit gaps, input bit busy_wr);
    int trig_i = -1, ew = 0, e, g0, coarse, idx;
    longint area = 0, exp_ts;
    for (int i = 0; i < len; i++)
      if (trig_i < 0 && pbuf[i] > thr_m) trig_i = i;
    for (int i = 0; i < 13; i++) area += pbuf[trig_i + i];
    coarse = (nsamp + trig_i) % 65536;
    idx = idx_of(pbuf[trig_i], area);
    exp_ts = ((longint'(coarse) << 6) - tbl_m[idx]) & ((64'd1 << 22) - 1);
    g0 = got_cnt;
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) send(4095, 1'b0, e);
      send(pbuf[i], 1'b1, e);
      if (busy_wr && i == trig_i + 2) begin
        cfg_we = 1'b1; cfg_addr = 9'(idx); cfg_wdata = 16'(tbl_m[idx] ^ 63);
      end
      if (i == trig_i + 12) ew = e;
    end
    for (int i = 0; i < 24; i++) send(0, 1'b1, e);
    check(got_cnt == g0 + 1, "R8", "result count", got_cnt - g0, 1);
    check(got_ts == exp_ts, req, "timestamp", got_ts, exp_ts);
    check(got_cyc == ew + 11, "R7", "latency edge", got_cyc, ew + 11);
  endtask

  task automatic t_reset();
    check(ts_valid == 1'b0, "R1", "ts_valid after reset", ts_valid, 0);
    check(ts == '0, "R1", "ts after reset", ts, 0);
  endtask

  task automatic t_config();
    for (int i = 0; i < 256; i++) wr_cfg(i, (i * 63) / 255);
    wr_cfg(256, 40);
    wr_cfg(257, 88);
    wr_cfg(258, 0);
  endtask

  task automatic t_borrow();
    fill_pulse(2000.0, 0.6, 0);
    run_pulse("R6 borrow", 24, 1'b0, 1'b0);
  endtask

  task automatic t_normal();
    fill_pulse(900.0, 0.1, 5);  run_pulse("R6 normal", 28, 1'b0, 1'b0);
    fill_pulse(3000.0, 0.45, 3); run_pulse("R5 normal", 28, 1'b0, 1'b0);
    fill_pulse(1500.0, 0.9, 7); run_pulse("R6 normal", 28, 1'b0, 1'b0);
  endtask

  task automatic t_gaps();
    fill_pulse(1800.0, 0.3, 4);
    run_pulse("R3 gaps", 26, 1'b1, 1'b0);
  endtask

  task automatic t_thr_equal();
    fill_pulse(1200.0, 0.5, 6);
    for (int i = 0; i < 4; i++) pbuf[i] = thr_m;
    run_pulse("R2 equal threshold", 28, 1'b0, 1'b0);
  endtask

  task automatic t_thr_change();
    wr_cfg(256, 300);
    fill_pulse(2500.0, 0.2, 6);
    pbuf[4] = 150; pbuf[5] = 250;
    run_pulse("R2 R9 raised threshold", 28, 1'b0, 1'b0);
    wr_cfg(256, 40);
  endtask

  task automatic t_sat();
    wr_cfg(257, 0); wr_cfg(258, 100);
    fill_pulse(1000.0, 0.3, 4); run_pulse("R5 saturate", 26, 1'b0, 1'b0);
    wr_cfg(258, 0);
    fill_pulse(700.0, 0.7, 4);  run_pulse("R4 clamp low", 26, 1'b0, 1'b0);
    wr_cfg(257, 65535);
    fill_pulse(1600.0, 0.2, 4); run_pulse("R4 clamp high", 26, 1'b0, 1'b0);
    wr_cfg(257, 88);
  endtask

  task automatic t_blind();
    fill_pulse(2200.0, 0.35, 4);
    for (int i = 17; i < 40; i++) pbuf[i] = 200;
    run_pulse("R8 plateau", 40, 1'b0, 1'b0);
    fill_pulse(1100.0, 0.55, 3);
    run_pulse("R8 rearm", 26, 1'b0, 1'b0);
  endtask

  task automatic t_busy_write();
    fill_pulse(1700.0, 0.25, 4);
    run_pulse("R9 write while busy", 26, 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_config();
    t_borrow();
    t_normal();
    t_gaps();
    t_thr_equal();
    t_thr_change();
    t_sat();
    t_blind();
    t_busy_write();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule